// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block puts a processor-style core into a low-power stop state on request and brings it back out. The stop request arrives asynchronously. It passes through a synchronizer chain, and only then does the controller act on it. On entry, the controller first raises a single-cycle acknowledge toward the bus side. In the next cycle it removes the clock enables of every core execution domain.

The enables for the bus interface and for the interrupt controller are never removed. Snooping and interrupt service therefore keep working while the core sleeps. When the synchronized request falls, the controller spends one resume cycle with the core enables already restored, then returns to normal running.

The outputs are one clock enable per core domain, one enable each for the bus and interrupt domains, the acknowledge pulse, and a stopped indicator. Real gating cells sit outside this block.

Top module: `stopclk_ctrl`

## Requirements
- R1: After a synchronous reset the block is running: every core enable is 1, `stop_ack` is 0 and `core_stopped` is 0.
- R2: A request first seen high at rising edge 1 (and held) makes `stop_ack` read 1 after edge 3 and not earlier. The delay comes from two synchronizer flops and then the state register.
- R3: `stop_ack` is high for exactly one cycle per entry into the stop state.
- R4: In the acknowledge cycle the core enables are still all 1. They drop to all 0 in the cycle right after the acknowledge.
- R5: `bus_clk_en` and `intr_clk_en` are 1 in every cycle, whether running, acknowledging, stopped or resuming.
- R6: While the synchronized request stays high, the block stays stopped with all core enables 0.
- R7: A request last seen high at edge L leads to a resume cycle after edge max(5, L+3): core enables are all 1 and `core_stopped` is 0. Normal running follows one cycle later, with no acknowledge.
- R8: A request withdrawn before or during the acknowledge cycle still completes entry. The block is stopped for at least the cycle after edge 4, then resumes.
- R9: `core_stopped` is 1 exactly when all core enables are 0, and it is 0 exactly when all core enables are 1.
- R10: A reset applied while stopped returns the block at once to the running state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock; it is never gated by this block |
| rst | input | 1 | Synchronous active-high reset |
| stop_req_async | input | 1 | Asynchronous stop request, active high |
| core_clk_en | output | NUM_CORE_DOMAINS | Clock enable per core execution domain |
| bus_clk_en | output | 1 | Clock enable of the bus interface domain |
| intr_clk_en | output | 1 | Clock enable of the interrupt controller domain |
| stop_ack | output | 1 | One-cycle acknowledge issued on stop entry |
| core_stopped | output | 1 | 1 while the core domains are stopped |

## Verification
The request is driven at the falling edge and sampled at edges numbered from 1. The acknowledge is due after edge 3 and the stopped state after edge 4. The resume cycle is due after edge max(5, L+3), where L is the last edge that saw the request high, and normal running follows one edge later. The bench sweeps the hold length L from 1 to 12 cycles and computes each of these edge numbers arithmetically. Every output is compared at the falling edge after each rising edge, so each comparison lands in the exact cycle in which that result is due.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;

    localparam int DEFAULT_CORE_DOMAINS = 4;
    localparam int DEFAULT_SYNC_STAGES  = 2;

    typedef enum logic [1:0] {
        PS_RUN     = 2'd0,
        PS_ACK     = 2'd1,
        PS_STOPPED = 2'd2,
        PS_RESUME  = 2'd3
    } pstate_t;

    typedef struct packed {
        logic ack;
        logic core_run;
        logic stopped;
    } pctl_t;

    function automatic pctl_t decode_state(pstate_t s);
        pctl_t c;
        c.ack      = (s == PS_ACK);
        c.stopped  = (s == PS_STOPPED);
        c.core_run = (s != PS_STOPPED);
        return c;
    endfunction

    function automatic pstate_t next_state(pstate_t s, logic req);
        pstate_t n;
        case (s)
            PS_RUN:     n = req ? PS_ACK : PS_RUN;
            PS_ACK:     n = PS_STOPPED;
            PS_STOPPED: n = req ? PS_STOPPED : PS_RESUME;
            default:    n = PS_RUN;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;

    generate
        if (STAGES < 2) begin : g_bad
            initial $error("stopclk_sync needs at least two stages");
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[TOP-1:0], din};
        end
    end

    assign dout = chain[TOP];

endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
    import stopclk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  req_sync,
    output pctl_t ctl
);
    pstate_t state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RUN;
        end else begin
            state <= next_state(state, req_sync);
        end
    end

    assign ctl = decode_state(state);

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl.ack) |-> $past(req_sync)); // R2
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.ack |=> !ctl.ack); // R3
    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (rst)
        (state == PS_ACK) |=> (state == PS_STOPPED)); // R8
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (state == PS_STOPPED && req_sync) |=> (state == PS_STOPPED)); // R6
    AST_RESUME_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        (state == PS_STOPPED && !req_sync) |=> (state == PS_RESUME)); // R7

endmodule

// File: rtl/stopclk_enables.sv
module stopclk_enables #(
    parameter int NUM_CORE = 4
) (
    input  logic                core_run,
    output logic [NUM_CORE-1:0] core_en,
    output logic                bus_en,
    output logic                intr_en
);
    genvar g;
    generate
        for (g = 0; g < NUM_CORE; g++) begin : g_core
            assign core_en[g] = core_run;
        end
    endgenerate

    assign bus_en  = 1'b1;
    assign intr_en = 1'b1;

endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
    import stopclk_pkg::*;
#(
    parameter int NUM_CORE_DOMAINS = DEFAULT_CORE_DOMAINS,
    parameter int SYNC_STAGES      = DEFAULT_SYNC_STAGES
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stop_req_async,
    output logic [NUM_CORE_DOMAINS-1:0] core_clk_en,
    output logic                        bus_clk_en,
    output logic                        intr_clk_en,
    output logic                        stop_ack,
    output logic                        core_stopped
);
    localparam logic [NUM_CORE_DOMAINS-1:0] ALL_ON = '1;

    logic  req_sync;
    pctl_t ctl;

    stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (stop_req_async),
        .dout (req_sync)
    );

    stopclk_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_sync (req_sync),
        .ctl      (ctl)
    );

    stopclk_enables #(.NUM_CORE(NUM_CORE_DOMAINS)) u_en (
        .core_run (ctl.core_run),
        .core_en  (core_clk_en),
        .bus_en   (bus_clk_en),
        .intr_en  (intr_clk_en)
    );

    assign stop_ack     = ctl.ack;
    assign core_stopped = ctl.stopped;

    AST_ACK_ENABLES_ON: assert property (@(posedge clk) disable iff (rst)
        stop_ack |-> (core_clk_en == ALL_ON)); // R4
    AST_ACK_THEN_OFF: assert property (@(posedge clk) disable iff (rst)
        stop_ack |=> (core_clk_en == '0)); // R4
    AST_STOP_VIA_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(core_stopped) |-> $past(stop_ack)); // R4
    AST_STOPPED_MATCH: assert property (@(posedge clk) disable iff (rst)
        core_stopped |-> (core_clk_en == '0)); // R9
    AST_RUNNING_MATCH: assert property (@(posedge clk) disable iff (rst)
        !core_stopped |-> (core_clk_en == ALL_ON)); // R9
    AST_UNCORE_ON: assert property (@(posedge clk) disable iff (rst)
        $rose(core_stopped) |-> (bus_clk_en && intr_clk_en)); // R5

endmodule

// File: tb/stopclk_ctrl_test.sv
module stopclk_ctrl_test;
    localparam int NC = 4;
    localparam logic [NC-1:0] ON = '1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic [NC-1:0] core_en;
    logic          bus_en, intr_en, ack, stopped;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    stopclk_ctrl #(.NUM_CORE_DOMAINS(NC), .SYNC_STAGES(2)) uut (
        .clk            (clk),
        .rst            (rst),
        .stop_req_async (req),
        .core_clk_en    (core_en),
        .bus_clk_en     (bus_en),
        .intr_clk_en    (intr_en),
        .stop_ack       (ack),
        .core_stopped   (stopped)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h time=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1: state right after reset
        chk("R1 core_en", 32'(core_en), 32'(ON));
        chk("R1 ack", 32'(ack), 0);
        chk("R1 stopped", 32'(stopped), 0);
        rst = 1'b0;
        tick();

        for (int len = 1; len <= 12; len++) begin
            int resume_edge;
            logic exp_stop;
            resume_edge = (len + 3 > 5) ? len + 3 : 5;
            req = 1'b1;
            for (int k = 1; k <= resume_edge + 3; k++) begin
                tick();
                exp_stop = (k >= 4) && (k < resume_edge);
                if (k == 3) chk("R2 ack due", 32'(ack), 1);
                else        chk("R3 ack single", 32'(ack), 0);
                if (k == 3 || k == 4)
                    chk("R4 enable timing", 32'(core_en), exp_stop ? 0 : 32'(ON));
                else if (k >= resume_edge)
                    chk("R7 resumed enables", 32'(core_en), 32'(ON));
                else
                    chk("R6 held enables", 32'(core_en), exp_stop ? 0 : 32'(ON));
                if (len <= 2)
                    chk("R8 withdraw during entry", 32'(stopped), 32'(exp_stop));
                else
                    chk("R6 stopped", 32'(stopped), 32'(exp_stop));
                chk("R5 bus_en", 32'(bus_en), 1);
                chk("R5 intr_en", 32'(intr_en), 1);
                chk("R9 indicator vs enables", 32'(stopped), 32'(core_en == '0));
                if (k == len) req = 1'b0;
            end
        end

        // R10: reset while stopped
        req = 1'b1;
        for (int k = 1; k <= 6; k++) tick();
        chk("R10 pre stopped", 32'(stopped), 1);
        rst = 1'b1;
        tick();
        chk("R10 core_en", 32'(core_en), 32'(ON));
        chk("R10 stopped", 32'(stopped), 0);
        chk("R10 ack", 32'(ack), 0);
        req = 1'b0;
        tick();
        rst = 1'b0;
        tick();
        chk("R1 after release", 32'(core_en), 32'(ON));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule